// File: doc/BRIEF.md
# Global-History Concatenated Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The index into the table is a global record of the most recent branch outcomes placed above a slice of the branch address. The address is first shifted right past the low bits that the instruction set always leaves zero.

Each request is one transaction. It carries the branch address and the outcome the branch already resolved to. In the cycle after the request is taken, the block shows the direction it predicted and raises a one-cycle mispredict pulse when that direction was wrong. On the same clock edge it moves the selected counter toward the outcome and shifts the outcome into the history. A saturating counter totals the mispredicts.

After reset, a sweep writes zero into every counter, one entry per cycle. A busy output is high for the whole sweep, and requests made while it is high are dropped.

Top module: `bp_ghist_concat`

## Requirements
- R1: The table holds 2^(HIST_W+IADDR_W) 2-bit counters. The index puts the HIST_W newest outcome bits in its upper part and address bits [LOW_ZERO+IADDR_W-1:LOW_ZERO] in its lower part. Each history value therefore selects its own entry for the same address.
- R2: Address bits below LOW_ZERO and above LOW_ZERO+IADDR_W-1 do not affect the prediction. Addresses that differ only in those bits share an entry.
- R3: pred_taken_o is 1 when the selected counter holds 2 or 3 and 0 when it holds 0 or 1. It is updated in the cycle after an accepted request and holds its value until the next accepted request.
- R4: A taken outcome increments the selected counter, stopping at 3. A not-taken outcome decrements it, stopping at 0. The new value is visible to a request made in the next cycle.
- R5: mispredict_o is high for exactly one cycle after an accepted request whose prediction differs from taken_i. It is low at all other times.
- R6: The lookup uses the history as it stood before the current branch. The history then shifts left by one, and taken_i enters at bit 0.
- R7: While rst_i is high and right after it, the history, the mispredict count, pred_taken_o and mispredict_o are zero and busy_o is 1. busy_o stays high for exactly 2^(HIST_W+IADDR_W) cycles after rst_i falls. When it drops, every counter reads 0, including counters that held other values before the reset.
- R8: A request made while busy_o is high, including in the sweep's last cycle, changes no counter, no history bit and no output.
- R9: miss_count_o rises by one on the same edge that raises mispredict_o, and stays at all ones once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; starts the clearing sweep |
| valid_i | input | 1 | A branch request is present |
| addr_i | input | ADDR_W | Address of the branch instruction |
| taken_i | input | 1 | Resolved outcome of the branch, 1 = taken |
| busy_o | output | 1 | Clearing sweep in progress; requests are dropped |
| pred_taken_o | output | 1 | Direction predicted for the last accepted request |
| mispredict_o | output | 1 | One-cycle pulse when that prediction was wrong |
| miss_count_o | output | CNT_W | Saturating total of mispredicts since reset |

## Verification
The sweep's final zero write and a request strobe can both be active in the same cycle. In that cycle the sweep must win, and the request must be lost rather than merged. The bench holds valid_i high through reset and through the entire sweep, then drops it in the first cycle that busy_o reads low. It judges the result in two ways: no pulse and no count while busy_o is high, and a vector table that begins from an all-zero history and gives the wrong expected values if any held request got in. A second case is a counter update and a read of the same entry in back-to-back cycles. The table exercises this with consecutive requests that hit one entry, and the expected values assume the read sees the new value.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    typedef logic [1:0] ctr2_t;

    // Move a 2-bit counter one step toward the outcome, clamped at 0 and 3.
    function automatic ctr2_t ctr2_next(ctr2_t c, logic up);
        if (up) return (c == 2'd3) ? c : ctr2_t'(c + 2'd1);
        else    return (c == 2'd0) ? c : ctr2_t'(c - 2'd1);
    endfunction

endpackage

// File: rtl/bpg_index.sv
module bpg_index #(
    parameter int ADDR_W   = 32,
    parameter int HIST_W   = 5,
    parameter int IADDR_W  = 5,
    parameter int LOW_ZERO = 2,
    localparam int IDX_W   = HIST_W + IADDR_W
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [HIST_W-1:0]  hist_i,
    output logic [IDX_W-1:0]   idx_o
);
    // history on top, shifted address slice below
    assign idx_o = {hist_i, addr_i[LOW_ZERO +: IADDR_W]};

    logic unused_addr;
    assign unused_addr = ^addr_i;
endmodule

// File: rtl/bpg_ctr_table.sv
module bpg_ctr_table
    import bpg_pkg::*;
#(
    parameter int IDX_W  = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output ctr2_t            rd_ctr_o,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  ctr2_t            wr_ctr_i
);
    ctr2_t mem_q [DEPTH];

    assign rd_ctr_o = mem_q[rd_idx_i];

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[wr_idx_i] <= wr_ctr_i;
    end
endmodule

// File: rtl/bpg_miss_count.sv
module bpg_miss_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/bp_ghist_concat.sv
module bp_ghist_concat
    import bpg_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int HIST_W   = 5,
    parameter int IADDR_W  = 5,
    parameter int LOW_ZERO = 2,
    parameter int CNT_W    = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              taken_i,
    output logic              busy_o,
    output logic              pred_taken_o,
    output logic              mispredict_o,
    output logic [CNT_W-1:0]  miss_count_o
);
    localparam int IDX_W = HIST_W + IADDR_W;

    typedef struct packed {
        logic              sweep;
        logic [IDX_W-1:0]  ptr;
        logic [HIST_W-1:0] hist;
        logic              pred;
        logic              miss;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] wr_idx;
    ctr2_t            rd_ctr, wr_ctr;
    logic             we, accept, pred_now;
    logic [HIST_W-1:0] hist_q;

    bpg_index #(
        .ADDR_W(ADDR_W), .HIST_W(HIST_W), .IADDR_W(IADDR_W), .LOW_ZERO(LOW_ZERO)
    ) u_index (
        .addr_i(addr_i),
        .hist_i(st_q.hist),
        .idx_o (look_idx)
    );

    bpg_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk_i   (clk_i),
        .rd_idx_i(look_idx),
        .rd_ctr_o(rd_ctr),
        .we_i    (we),
        .wr_idx_i(wr_idx),
        .wr_ctr_i(wr_ctr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.miss = 1'b0;
        accept   = valid_i && !st_q.sweep;
        pred_now = rd_ctr[1];
        we       = 1'b0;
        wr_idx   = look_idx;
        wr_ctr   = ctr2_next(rd_ctr, taken_i);
        if (st_q.sweep) begin
            we      = 1'b1;
            wr_idx  = st_q.ptr;
            wr_ctr  = 2'd0;
            st_d.ptr = st_q.ptr + 1'b1;
            if (st_q.ptr == '1) st_d.sweep = 1'b0;
        end else if (accept) begin
            we        = 1'b1;
            st_d.pred = pred_now;
            st_d.miss = pred_now ^ taken_i;
            st_d.hist = (st_q.hist << 1) | HIST_W'(taken_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '{sweep: 1'b1, default: '0};
        else       st_q <= st_d;
    end

    bpg_miss_count #(.CNT_W(CNT_W)) u_count (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .inc_i  (st_d.miss),
        .count_o(miss_count_o)
    );

    assign hist_q       = st_q.hist;
    assign busy_o       = st_q.sweep;
    assign pred_taken_o = st_q.pred;
    assign mispredict_o = st_q.miss;
endmodule

// File: rtl/bpg_chk.sv
module bpg_chk #(
    parameter int HIST_W = 5,
    parameter int CNT_W  = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              valid_i,
    input logic              taken_i,
    input logic              busy_o,
    input logic              pred_taken_o,
    input logic              mispredict_o,
    input logic [CNT_W-1:0]  miss_count_o,
    input logic [HIST_W-1:0] hist_q
);
    // R6
    hist_shift_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i && !busy_o |=> hist_q == (($past(hist_q) << 1) | HIST_W'($past(taken_i))));

    // R5
    miss_dir_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mispredict_o |-> pred_taken_o != $past(taken_i));

    // R5
    miss_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mispredict_o |-> $past(valid_i && !busy_o));

    // R8
    busy_block_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |=> !mispredict_o && $stable(hist_q));

    // R9
    count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && miss_count_o != $past(miss_count_o)
        |-> miss_count_o == $past(miss_count_o) + 1'b1);

    // R9
    count_sat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        miss_count_o == '1 |=> miss_count_o == '1);
endmodule

bind bp_ghist_concat bpg_chk #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .valid_i     (valid_i),
    .taken_i     (taken_i),
    .busy_o      (busy_o),
    .pred_taken_o(pred_taken_o),
    .mispredict_o(mispredict_o),
    .miss_count_o(miss_count_o),
    .hist_q      (hist_q)
);

// File: tb/sim_bp_ghist_concat.sv
module sim_bp_ghist_concat;
    localparam int ADDR_W = 16;
    localparam int HW     = 5;
    localparam int AW     = 5;
    localparam int CW     = 4;
    localparam int DEPTH  = 1 << (HW + AW);

    // {addr[7:0], taken, expected pred, expected miss}
    localparam logic [10:0] VEC [29] = '{
        {8'h40,3'b101}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000},
        {8'h41,3'b101}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000},
        {8'h43,3'b110}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000},
        {8'hC0,3'b110}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b000},
        {8'h40,3'b011}, {8'h40,3'b011}, {8'h40,3'b000}, {8'h40,3'b000}, {8'h40,3'b101}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              valid = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              taken = 1'b0;
    logic              busy, pred, miss;
    logic [CW-1:0]     cnt;

    int total = 0;
    int bad   = 0;
    int exp_cnt = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bp_ghist_concat #(
        .ADDR_W(ADDR_W), .HIST_W(HW), .IADDR_W(AW), .LOW_ZERO(2), .CNT_W(CW)
    ) u0 (
        .clk_i(clk), .rst_i(rst), .valid_i(valid), .addr_i(addr), .taken_i(taken),
        .busy_o(busy), .pred_taken_o(pred), .mispredict_o(miss), .miss_count_o(cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one request per cycle; outputs sampled at the following falling edge
    task automatic req(input logic [ADDR_W-1:0] a, input logic t);
        valid = 1'b1; addr = a; taken = t;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic bump(input logic m);
        if (m && exp_cnt < 15) exp_cnt++;
    endtask

    task automatic wait_sweep(output int cyc);
        cyc = 0;
        while (busy && cyc < DEPTH + 10) begin
            if (miss !== 1'b0) chk(1'b0, "R8 pulse while busy", int'(miss), 0);
            if (cnt !== '0)    chk(1'b0, "R8 count while busy", int'(cnt), 0);
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        int cyc;
        // hold a request through reset and the whole sweep
        valid = 1'b1; addr = 16'h0040; taken = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy === 1'b1, "R7 busy in reset", int'(busy), 1);
        chk(cnt === '0, "R7 count in reset", int'(cnt), 0);
        chk(miss === 1'b0 && pred === 1'b0, "R7 outputs in reset", int'({pred, miss}), 0);
        rst = 1'b0;
        wait_sweep(cyc);
        valid = 1'b0;
        chk(cyc == DEPTH, "R7 sweep length", cyc, DEPTH);
        chk(cnt === '0 && miss === 1'b0, "R8 held request dropped", int'(cnt), 0);

        // vector walk: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 29; i++) begin
            logic [10:0] v;
            v = VEC[i];
            req({8'h00, v[10:3]}, v[2]);
            bump(v[0]);
            chk(pred === v[1], $sformatf("R3 pred row %0d", i), int'(pred), int'(v[1]));
            chk(miss === v[0], $sformatf("R5 miss row %0d", i), int'(miss), int'(v[0]));
            chk(int'(cnt) == exp_cnt, $sformatf("R9 count row %0d", i), int'(cnt), exp_cnt);
        end
        @(negedge clk);
        chk(miss === 1'b0, "R5 pulse one cycle", int'(miss), 0);
        chk(pred === 1'b0, "R3 pred holds", int'(pred), 0);

        // fresh entries, all mispredicts, count clamps at all ones
        for (int i = 0; i < 12; i++) begin
            req(16'((17 + i) << 2), 1'b1);
            bump(1'b1);
            chk(miss === 1'b1, "R1 fresh entry miss", int'(miss), 1);
        end
        chk(int'(cnt) == 15, "R9 saturation", int'(cnt), 15);

        // train entry (history all ones, addr 0x40) up, then reset
        for (int i = 0; i < 8; i++) req(16'h0040, 1'b1);
        req(16'h0040, 1'b1);
        chk(pred === 1'b1, "R4 trained taken", int'(pred), 1);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(cnt === '0 && busy === 1'b1, "R7 re-reset state", int'(cnt), 0);
        rst = 1'b0;
        wait_sweep(cyc);
        chk(cyc == DEPTH, "R7 second sweep length", cyc, DEPTH);
        for (int i = 0; i < 5; i++) req(16'h0040, 1'b1);
        req(16'h0040, 1'b1);
        chk(pred === 1'b0 && miss === 1'b1, "R7 sweep cleared trained entry", int'(pred), 0);
        chk(int'(cnt) == 6, "R9 count after re-reset", int'(cnt), 6);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule